// File: doc/BRIEF.md
# Addressed Peripheral Port

This block is the bus-side front end that ties a single peripheral to a shared I/O bus. On every cycle it compares the bus address with a device address supplied on a configuration input. It acts on a command only when the select strobe is high and the addresses agree. On any other cycle it leaves all of its state alone and keeps its read bus at zero.

Four command classes are carried on a 2-bit function field:

- **Control** sets the peripheral's control lines, which select its task and mode.
- **Status** returns a word that combines the interface's own occupancy flags with condition bits from the peripheral.
- **Data out** places the bus word in a holding register. The peripheral drains that register over a valid/ready stream.
- **Data in** returns the word the peripheral last pushed into a one-entry input buffer over a second valid/ready stream, and frees the buffer.

Back-pressure works the same way on both streams. A word moves only on a clock edge where valid and ready are both high. The valid side holds its data steady until that edge. The input stream is stalled, with `pin_ready` low, while the buffer is still full and has not been read. Status reads and data-in reads are answered one cycle after the strobe, on a read bus that carries a valid flag.

Top module: `pio_port_if`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `per_ctrl`, `rd_valid`, `rd_data` and `pout_valid` are 0, and `pin_ready` is 1.
- R2: A strobe whose `bus_addr` differs from `dev_addr` has no effect. After it, `per_ctrl`, the output register and the input buffer are unchanged, and `rd_valid` stays 0.
- R3: A matching strobe with function 00 (control) loads `bus_wdata[CTRL_W-1:0]` into `per_ctrl`, which is visible the cycle after the strobe.
- R4: A matching strobe with function 01 (status) raises `rd_valid` for one cycle, the cycle after the strobe. In that cycle `rd_data` holds:
  - bit 0: input-buffer-full flag
  - bit 1: output-register-full flag
  - bits [2+STAT_W-1:2]: `per_stat`
  - all other bits: 0

  All of these values are sampled at the strobe edge.
- R5: A matching strobe with function 10 (data out) while the output register is empty stores `bus_wdata`. In the next cycle `pout_valid` is 1 and `pout_data` equals that word.
- R6: A data-out strobe while the output register is still full is ignored. `pout_data` keeps the earlier word and `pout_valid` stays 1.
- R7: The output register empties on the edge where `pout_valid` and `pout_ready` are both 1. While `pout_ready` is 0, `pout_valid` and `pout_data` hold steady.
- R8: `pin_ready` is 1 exactly when the input buffer is empty. A word on `pin_data` is captured on an edge where `pin_valid` and `pin_ready` are both 1, which sets the full flag and drops `pin_ready`.
- R9: A matching strobe with function 11 (data in) raises `rd_valid` for one cycle, the cycle after the strobe, with `rd_data` equal to the buffer word held at the strobe edge, and empties the buffer. If the buffer is empty when that strobe comes and `pin_valid` is high on the same edge, the new word is captured and the buffer stays full.
- R10: `rd_data` is 0 in every cycle where `rd_valid` is 0. Control and data-out strobes never raise `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_addr | input | ADDR_W | Device address this port answers to |
| bus_sel | input | 1 | Single-cycle command strobe |
| bus_addr | input | ADDR_W | Bus address lines |
| bus_func | input | 2 | Command class: 00 control, 01 status, 10 data out, 11 data in |
| bus_wdata | input | DATA_W | Bus write data |
| rd_valid | output | 1 | Read response valid, one cycle after the strobe |
| rd_data | output | DATA_W | Read response data, 0 when not valid |
| per_ctrl | output | CTRL_W | Peripheral control lines |
| per_stat | input | STAT_W | Peripheral condition bits |
| pout_valid | output | 1 | Output word available to the peripheral |
| pout_ready | input | 1 | Peripheral takes the output word |
| pout_data | output | DATA_W | Output word |
| pin_valid | input | 1 | Peripheral offers an input word |
| pin_ready | output | 1 | Input buffer empty and able to accept |
| pin_data | input | DATA_W | Input word from the peripheral |

## Verification
Random traffic mixes matching and non-matching addresses across all four function codes. Non-matching traffic must leave no trace, which separates a correct address compare from one that ignores some bits. Both readiness inputs toggle randomly, so data-out strobes land on both an empty and a full output register, and data-in strobes land on both a filled and an empty buffer. That separates overwrite-on-full errors from correct dropping, and shows whether a capture on the same edge as a read wins. Directed steps cover the reset state, a near-miss address, back-to-back data-out writes under a stalled peripheral, and a read of an empty buffer.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    FN_CTRL = 2'b00,
    FN_STAT = 2'b01,
    FN_WR   = 2'b10,
    FN_RD   = 2'b11
  } pio_fn_e;
endpackage

// File: rtl/pio_addr_match.sv
module pio_addr_match #(
  parameter int ADDR_W = 8
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [1:0]        func,
  output logic              hit_ctrl,
  output logic              hit_stat,
  output logic              hit_wr,
  output logic              hit_rd
);
  import pio_pkg::*;
  logic hit;
  assign hit = sel && (bus_addr == dev_addr);

  always_comb begin
    hit_ctrl = 1'b0;
    hit_stat = 1'b0;
    hit_wr   = 1'b0;
    hit_rd   = 1'b0;
    if (hit) begin
      unique case (pio_fn_e'(func))
        FN_CTRL: hit_ctrl = 1'b1;
        FN_STAT: hit_stat = 1'b1;
        FN_WR:   hit_wr   = 1'b1;
        FN_RD:   hit_rd   = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/pio_out_stage.sv
module pio_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);
  logic         full_q;
  logic [W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else if (!full_q) begin
      if (load) begin
        full_q <= 1'b1;
        word_q <= load_data;
      end
    end else if (ready) begin
      full_q <= 1'b0;
    end
  end

  assign valid = full_q;
  assign data  = word_q;
endmodule

// File: rtl/pio_in_buf.sv
module pio_in_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] word
);
  logic         full_q;
  logic [W-1:0] word_q;
  logic         cap;

  assign cap = in_valid && !full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else if (cap) begin
      full_q <= 1'b1;
      word_q <= in_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  assign in_ready = !full_q;
  assign full     = full_q;
  assign word     = word_q;
endmodule

// File: rtl/pio_port_if.sv
module pio_port_if #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CTRL_W = 8,
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_func,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [CTRL_W-1:0] per_ctrl,
  input  logic [STAT_W-1:0] per_stat,
  output logic              pout_valid,
  input  logic              pout_ready,
  output logic [DATA_W-1:0] pout_data,
  input  logic              pin_valid,
  output logic              pin_ready,
  input  logic [DATA_W-1:0] pin_data
);
  localparam int STAT_LSB = 2;
  localparam int STAT_MSB = STAT_LSB + STAT_W - 1;

  logic hit_ctrl, hit_stat, hit_wr, hit_rd;
  logic in_full;
  logic [DATA_W-1:0] in_word;
  logic [DATA_W-1:0] stat_word;
  logic [CTRL_W-1:0] ctrl_q;
  logic              rv_q;
  logic [DATA_W-1:0] rd_q;

  pio_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .sel(bus_sel), .bus_addr(bus_addr), .dev_addr(dev_addr), .func(bus_func),
    .hit_ctrl(hit_ctrl), .hit_stat(hit_stat), .hit_wr(hit_wr), .hit_rd(hit_rd)
  );

  pio_out_stage #(.W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(hit_wr), .load_data(bus_wdata),
    .ready(pout_ready), .valid(pout_valid), .data(pout_data)
  );

  pio_in_buf #(.W(DATA_W)) u_in (
    .clk(clk), .rst_n(rst_n), .in_valid(pin_valid), .in_data(pin_data),
    .in_ready(pin_ready), .take(hit_rd), .full(in_full), .word(in_word)
  );

  always_comb begin
    stat_word = '0;
    stat_word[0] = in_full;
    stat_word[1] = pout_valid;
    stat_word[STAT_MSB:STAT_LSB] = per_stat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rv_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (hit_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
      rv_q <= hit_stat | hit_rd;
      if (hit_stat)    rd_q <= stat_word;
      else if (hit_rd) rd_q <= in_word;
      else             rd_q <= '0;
    end
  end

  assign per_ctrl = ctrl_q;
  assign rd_valid = rv_q;
  assign rd_data  = rd_q;
endmodule

// File: rtl/pio_port_if_chk.sv
module pio_port_if_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] dev_addr,
  input logic              bus_sel,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_func,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [CTRL_W-1:0] per_ctrl,
  input logic              pout_valid,
  input logic              pout_ready,
  input logic [DATA_W-1:0] pout_data,
  input logic              pin_valid,
  input logic              pin_ready
);
  logic miss;
  logic match;
  assign miss  = bus_sel && (bus_addr != dev_addr);
  assign match = bus_sel && (bus_addr == dev_addr);

  // R10
  rd_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0);

  // R2
  miss_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> !rd_valid);

  // R2
  miss_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> $stable(per_ctrl));

  // R3
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && bus_func == 2'b00) |=> per_ctrl == $past(bus_wdata[CTRL_W-1:0]));

  // R4
  stat_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && bus_func == 2'b01) |=> rd_valid);

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pout_valid && !pout_ready) |=> pout_valid && $stable(pout_data));

  // R8
  in_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_valid && pin_ready) |=> !pin_ready);
endmodule

bind pio_port_if pio_port_if_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .bus_sel(bus_sel),
  .bus_addr(bus_addr), .bus_func(bus_func), .bus_wdata(bus_wdata),
  .rd_valid(rd_valid), .rd_data(rd_data), .per_ctrl(per_ctrl),
  .pout_valid(pout_valid), .pout_ready(pout_ready), .pout_data(pout_data),
  .pin_valid(pin_valid), .pin_ready(pin_ready)
);

// File: tb/pio_port_if_tb.sv
module pio_port_if_tb_top;
  localparam int AW = 8, DW = 8, CW = 8, SW = 4;
  localparam logic [AW-1:0] DEV = 8'h5A;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] dev_addr = DEV;
  logic bus_sel;
  logic [AW-1:0] bus_addr;
  logic [1:0] bus_func;
  logic [DW-1:0] bus_wdata;
  logic rd_valid;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] per_ctrl;
  logic [SW-1:0] per_stat;
  logic pout_valid, pout_ready;
  logic [DW-1:0] pout_data;
  logic pin_valid, pin_ready;
  logic [DW-1:0] pin_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic [CW-1:0] m_ctrl;
  logic m_ofull, m_ifull;
  logic [DW-1:0] m_odata, m_idata;

  always #10 clk = ~clk;

  pio_port_if #(.ADDR_W(AW), .DATA_W(DW), .CTRL_W(CW), .STAT_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .bus_sel(bus_sel),
    .bus_addr(bus_addr), .bus_func(bus_func), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .per_ctrl(per_ctrl),
    .per_stat(per_stat), .pout_valid(pout_valid), .pout_ready(pout_ready),
    .pout_data(pout_data), .pin_valid(pin_valid), .pin_ready(pin_ready),
    .pin_data(pin_data)
  );

  function automatic logic [DW-1:0] stat_word(logic ifull, logic ofull,
                                                logic [SW-1:0] st);
    logic [DW-1:0] w;
    w = '0;
    w[0] = ifull;
    w[1] = ofull;
    w[2 +: SW] = st;
    return w;
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // one bus cycle: drive at negedge, update model, check after the edge
  task automatic step(logic sel, logic [AW-1:0] addr, logic [1:0] fn,
                      logic [DW-1:0] wd, logic prdy, logic pvld, logic [DW-1:0] pd);
    logic hit, e_rv;
    logic [DW-1:0] e_rd;
    string rq;
    bus_sel = sel; bus_addr = addr; bus_func = fn; bus_wdata = wd;
    pout_ready = prdy; pin_valid = pvld; pin_data = pd;
    per_stat = SW'($urandom);
    hit = sel && (addr == DEV);
    e_rv = hit && (fn == 2'b01 || fn == 2'b11);
    e_rd = '0;
    if (hit && fn == 2'b01) e_rd = stat_word(m_ifull, m_ofull, per_stat);
    if (hit && fn == 2'b11) e_rd = m_idata;
    rq = !hit ? (sel ? "R2" : "R10") : (fn == 2'b00 ? "R3" : fn == 2'b01 ? "R4" :
         fn == 2'b10 ? "R5" : "R9");
    // next state
    if (hit && fn == 2'b00) m_ctrl = wd[CW-1:0];
    if (!m_ofull) begin
      if (hit && fn == 2'b10) begin m_ofull = 1'b1; m_odata = wd; end
    end else begin
      if (hit && fn == 2'b10) rq = "R6";
      if (prdy) m_ofull = 1'b0;
    end
    if (pvld && !m_ifull) begin m_ifull = 1'b1; m_idata = pd; end
    else if (hit && fn == 2'b11) m_ifull = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(rq, "rd_valid", 32'(rd_valid), 32'(e_rv));
    chk(e_rv ? rq : "R10", "rd_data", 32'(rd_data), 32'(e_rd));
    chk(rq, "per_ctrl", 32'(per_ctrl), 32'(m_ctrl));
    chk("R7", "pout_valid", 32'(pout_valid), 32'(m_ofull));
    if (m_ofull) chk(rq == "R6" ? "R6" : "R5", "pout_data", 32'(pout_data), 32'(m_odata));
    chk("R8", "pin_ready", 32'(pin_ready), 32'(!m_ifull));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    rst_n = 1'b0; bus_sel = 0; bus_addr = 0; bus_func = 0; bus_wdata = 0;
    pout_ready = 0; pin_valid = 0; pin_data = 0; per_stat = 0;
    m_ctrl = '0; m_ofull = 0; m_ifull = 0; m_odata = '0; m_idata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "per_ctrl", 32'(per_ctrl), 0);
    chk("R1", "rd_valid", 32'(rd_valid), 0);
    chk("R1", "rd_data", 32'(rd_data), 0);
    chk("R1", "pout_valid", 32'(pout_valid), 0);
    chk("R1", "pin_ready", 32'(pin_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rd_valid after release", 32'(rd_valid), 0);
    chk("R1", "pin_ready after release", 32'(pin_ready), 1);

    // directed corners
    step(1, DEV ^ 8'h01, 2'b00, 8'hA5, 0, 0, 0);  // R2 near-miss control
    step(1, DEV ^ 8'h80, 2'b10, 8'h11, 0, 0, 0);  // R2 near-miss data out
    step(1, DEV, 2'b00, 8'h3C, 0, 0, 0);          // R3 control
    step(1, DEV, 2'b10, 8'h77, 0, 0, 0);          // R5 load
    step(1, DEV, 2'b10, 8'h88, 0, 0, 0);          // R6 dropped on full
    step(1, DEV, 2'b01, 8'h00, 0, 0, 0);          // R4 status, out full
    step(0, DEV, 2'b00, 8'h00, 1, 0, 0);          // R7 drain
    step(1, DEV, 2'b11, 8'h00, 0, 0, 0);          // R9 read empty buffer
    step(0, DEV, 2'b00, 8'h00, 0, 1, 8'hE1);      // R8 capture
    step(0, DEV, 2'b00, 8'h00, 0, 1, 8'hE2);      // R8 stalled
    step(1, DEV, 2'b01, 8'h00, 0, 0, 0);          // R4 status, in full
    step(1, DEV, 2'b11, 8'h00, 0, 1, 8'hE3);      // R9 read, then refill
    step(1, DEV, 2'b11, 8'h00, 0, 1, 8'hE4);      // R9 read+capture same edge

    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      a = ($urandom_range(0, 9) < 7) ? DEV : AW'($urandom);
      step(1'($urandom_range(0, 3) != 0), a, 2'($urandom), DW'($urandom),
           1'($urandom), 1'($urandom), DW'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule